// File: doc/BRIEF.md
# Parallel Bus Region Timing Sequencer

This block sequences one access on a single chip-select region of an asynchronous parallel peripheral bus. One example is a removable flash card running in programmed I/O mode. A host-side request port supplies an address, a direction flag and write data. The block then drives the address, the active-low chip enable, the output enable, the write enable and the write-data bus. On a read, it returns the data it sampled from the device.

Each phase of the access has its own length field, counted in bus clocks. The phases are:

- address setup before chip enable;
- chip enable to strobe;
- strobe width, with separate fields for reads and writes;
- hold after the strobe, with separate fields for reads and writes;
- an idle pause that closes the cycle.

A two-bit multiplier scales every field. When dynamic wait is enabled, a device that is not ready can stretch the strobe through an active-low wait input. A separate post-ready time then keeps the strobe asserted after the device becomes ready.

The request port follows valid/ready rules. The host raises `req_valid` and holds the address, direction and write data stable. The block samples the request only while it is idle and the region is enabled. `req_ready` pulses for exactly one clock when the whole cycle, pause included, has finished, and `rsp_rdata` is valid in that same clock. The host drops or replaces the request after that pulse. No second request is taken until then, so back-pressure is simply the length of the current access.

Top module: `bus_region_seq`

## Requirements
- R1: After reset, `bus_ce_n`, `bus_oe_n` and `bus_we_n` are high, and `req_ready` and `bus_dout_en` are low.
- R2: After a request is accepted, `bus_addr` shows the request address with chip enable high for exactly `cfg_adr`×M clocks before `bus_ce_n` falls. The address stays stable while chip enable is low. Any phase whose scaled length is zero takes no clocks.
- R3: With chip enable low, the strobe starts after exactly `cfg_ce`×M clocks.
- R4: A read asserts only `bus_oe_n`, for `cfg_oe`×M clocks. A write asserts only `bus_we_n`, for `cfg_we`×M clocks. A strobe is asserted only while chip enable is low.
- R5: After the strobe ends, chip enable stays low for `cfg_rd_hld`×M clocks after a read or `cfg_wr_hld`×M clocks after a write.
- R6: After chip enable rises, `cfg_pause`×M idle clocks pass before `req_ready` is asserted.
- R7: The multiplier M is set by `cfg_mult`: code 0 gives ×4, code 1 gives ×1, code 2 gives ×2 and code 3 gives ×8.
- R8: With `cfg_wait_en` high, the strobe phase is never skipped. Once its width has elapsed, it continues while `bus_wait_n` is low, then stays asserted for `cfg_post_rdy`×M further clocks. With `cfg_wait_en` low, `bus_wait_n` and `cfg_post_rdy` have no effect.
- R9: On a read, `rsp_rdata` holds the value `bus_din` had at the clock edge that ends the last clock in which `bus_oe_n` is low.
- R10: On a write, `bus_dout` carries the write data and `bus_dout_en` is high for every clock in which chip enable is low.
- R11: While `cfg_en` is low, requests are ignored: chip enable stays high and `req_ready` stays low.
- R12: `req_ready` is high for one clock per accepted request, at the end of the cycle. No new request is accepted before that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Region enable |
| cfg_mult | input | 2 | Timing multiplier code |
| cfg_adr | input | FIELD_W | Address setup before chip enable |
| cfg_ce | input | FIELD_W | Chip enable to strobe delay |
| cfg_oe | input | FIELD_W | Output enable width |
| cfg_we | input | FIELD_W | Write enable width |
| cfg_rd_hld | input | FIELD_W | Chip enable hold after read |
| cfg_wr_hld | input | FIELD_W | Chip enable hold after write |
| cfg_pause | input | FIELD_W | Idle time closing the cycle |
| cfg_wait_en | input | 1 | Dynamic wait enable |
| cfg_post_rdy | input | FIELD_W | Strobe time kept after ready returns |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | One-clock completion pulse |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Read data, valid with req_ready |
| bus_addr | output | ADDR_W | Bus address |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_dout | output | DATA_W | Bus write data |
| bus_dout_en | output | 1 | Drive enable for bus_dout |
| bus_din | input | DATA_W | Bus read data |
| bus_wait_n | input | 1 | Device ready, low = stretch strobe |

## Verification
Reads and writes run with distinct field values in every phase, so that swapping one phase length for another changes a measured count. The same fields are rerun under each multiplier code to tell the encodings apart. An all-zero setup, delay, hold and pause pattern shows that empty phases are skipped and not rounded up to one clock. The read-data input changes on every strobe clock, which pins the capture to the edge where the strobe deasserts. Wait is tested in three ways: held low with the feature off, released late with it on, and high from the start with it on. Together these separate stretching from the post-ready time.

// File: rtl/brs_pkg.sv
package brs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADR   = 3'd1,
    PH_CE    = 3'd2,
    PH_STB   = 3'd3,
    PH_POST  = 3'd4,
    PH_HLD   = 3'd5,
    PH_PAUSE = 3'd6,
    PH_DONE  = 3'd7
  } phase_e;

  localparam int NUM_PHASES = 8;

  // Shift amount for each multiplier code: 0 -> x4, 1 -> x1, 2 -> x2, 3 -> x8
  function automatic logic [1:0] mult_shift(input logic [1:0] code);
    logic [1:0] sh;
    case (code)
      2'd0:    sh = 2'd2;
      2'd1:    sh = 2'd0;
      2'd2:    sh = 2'd1;
      default: sh = 2'd3;
    endcase
    return sh;
  endfunction

  function automatic logic is_strobe(input phase_e p);
    return (p == PH_STB) || (p == PH_POST);
  endfunction

endpackage

// File: rtl/brs_scale.sv
module brs_scale
  import brs_pkg::*;
#(
  parameter int FIELD_W = 6,
  localparam int LEN_W = FIELD_W + 3
) (
  input  logic [FIELD_W-1:0] field,
  input  logic [1:0]         mult,
  output logic [LEN_W-1:0]   len
);
  logic [1:0] sh;

  always_comb begin
    sh  = mult_shift(mult);
    len = LEN_W'(field) << sh;
  end
endmodule

// File: rtl/brs_counter.sv
module brs_counter #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/brs_capture.sv
module brs_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
    end else if (sample) begin
      dout <= din;
    end
  end
endmodule

// File: rtl/bus_region_seq.sv
module bus_region_seq
  import brs_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 16,
  parameter int FIELD_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_en,
  input  logic [1:0]         cfg_mult,
  input  logic [FIELD_W-1:0] cfg_adr,
  input  logic [FIELD_W-1:0] cfg_ce,
  input  logic [FIELD_W-1:0] cfg_oe,
  input  logic [FIELD_W-1:0] cfg_we,
  input  logic [FIELD_W-1:0] cfg_rd_hld,
  input  logic [FIELD_W-1:0] cfg_wr_hld,
  input  logic [FIELD_W-1:0] cfg_pause,
  input  logic               cfg_wait_en,
  input  logic [FIELD_W-1:0] cfg_post_rdy,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic               bus_ce_n,
  output logic               bus_oe_n,
  output logic               bus_we_n,
  output logic [DATA_W-1:0]  bus_dout,
  output logic               bus_dout_en,
  input  logic [DATA_W-1:0]  bus_din,
  input  logic               bus_wait_n
);
  localparam int LEN_W = FIELD_W + 3;
  localparam int NPH   = NUM_PHASES;

  phase_e              phase_q, phase_nxt, skip_nxt;
  logic                wr_q, wr_eff;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [FIELD_W-1:0]  fld  [NPH];
  logic [LEN_W-1:0]    plen [NPH];
  logic [NPH-1:0]      nz;
  logic                cnt_zero, wait_hold, adv, cap_sample, busy;
  logic [LEN_W-1:0]    load_val;

  // Direction of the access in flight, or of the one about to be accepted
  assign wr_eff = (phase_q == PH_IDLE) ? req_write : wr_q;

  // Raw field for every phase slot; idle and done have no length
  always_comb begin
    for (int i = 0; i < NPH; i++) fld[i] = '0;
    fld[PH_ADR]   = cfg_adr;
    fld[PH_CE]    = cfg_ce;
    fld[PH_STB]   = wr_eff ? cfg_we : cfg_oe;
    fld[PH_POST]  = cfg_wait_en ? cfg_post_rdy : '0;
    fld[PH_HLD]   = wr_eff ? cfg_wr_hld : cfg_rd_hld;
    fld[PH_PAUSE] = cfg_pause;
  end

  for (genvar g = 0; g < NPH; g++) begin : g_scale
    brs_scale #(.FIELD_W(FIELD_W)) u_scale (
      .field (fld[g]),
      .mult  (cfg_mult),
      .len   (plen[g])
    );
  end

  // Which phases are present in this access
  always_comb begin
    for (int i = 0; i < NPH; i++) nz[i] = (plen[i] != '0);
    nz[PH_IDLE] = 1'b0;
    nz[PH_STB]  = nz[PH_STB] | cfg_wait_en;
    nz[PH_DONE] = 1'b1;
  end

  // Lowest present phase after the current one
  always_comb begin
    skip_nxt = PH_DONE;
    for (int i = NPH - 2; i >= 1; i--) begin
      if ((i > int'(phase_q)) && nz[i]) skip_nxt = phase_e'(3'(i));
    end
  end

  assign wait_hold = (phase_q == PH_STB) && cfg_wait_en && !bus_wait_n;

  always_comb begin
    case (phase_q)
      PH_IDLE: adv = cfg_en && req_valid;
      PH_DONE: adv = 1'b1;
      default: adv = cnt_zero && !wait_hold;
    endcase
  end

  always_comb begin
    if (!adv)                    phase_nxt = phase_q;
    else if (phase_q == PH_DONE) phase_nxt = PH_IDLE;
    else                         phase_nxt = skip_nxt;
  end

  assign load_val = (plen[phase_nxt] == '0) ? '0 : plen[phase_nxt] - LEN_W'(1);

  brs_counter #(.W(LEN_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (adv),
    .load_val (load_val),
    .zero     (cnt_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      phase_q <= phase_nxt;
      if ((phase_q == PH_IDLE) && adv) begin
        wr_q    <= req_write;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  // Read data is taken on the edge where output enable deasserts
  assign cap_sample = adv && !wr_q && is_strobe(phase_q) && !is_strobe(phase_nxt);

  brs_capture #(.DATA_W(DATA_W)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .sample (cap_sample),
    .din    (bus_din),
    .dout   (rsp_rdata)
  );

  logic ce_act, stb_act;
  assign ce_act  = (phase_q == PH_CE) || is_strobe(phase_q) || (phase_q == PH_HLD);
  assign stb_act = is_strobe(phase_q);
  assign busy    = (phase_q != PH_IDLE);

  assign req_ready   = (phase_q == PH_DONE);
  assign bus_addr    = addr_q;
  assign bus_ce_n    = !ce_act;
  assign bus_oe_n    = !(stb_act && !wr_q);
  assign bus_we_n    = !(stb_act && wr_q);
  assign bus_dout    = wdata_q;
  assign bus_dout_en = ce_act && wr_q;
endmodule

// File: rtl/bus_region_seq_chk.sv
module bus_region_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_en,
  input logic              busy,
  input logic              req_ready,
  input logic              bus_ce_n,
  input logic              bus_oe_n,
  input logic              bus_we_n,
  input logic              bus_dout_en,
  input logic [ADDR_W-1:0] bus_addr
);
  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_oe_n && !bus_we_n));

  // R4
  strobe_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_oe_n || !bus_we_n) |-> !bus_ce_n);

  // R12
  ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  // R12
  ready_after_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> bus_ce_n);

  // R11
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cfg_en) |=> bus_ce_n);

  // R10
  write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we_n |-> bus_dout_en);

  // R2
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ce_n |=> (bus_ce_n || $stable(bus_addr)));
endmodule

bind bus_region_seq bus_region_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_en      (cfg_en),
  .busy        (busy),
  .req_ready   (req_ready),
  .bus_ce_n    (bus_ce_n),
  .bus_oe_n    (bus_oe_n),
  .bus_we_n    (bus_we_n),
  .bus_dout_en (bus_dout_en),
  .bus_addr    (bus_addr)
);

// File: tb/tb_bus_region_seq.sv
module tb_bus_region_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 16;
  localparam int FW = 6;
  localparam logic [DW-1:0] RD_BASE = 16'hA500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b1;
  logic [1:0] cfg_mult = 2'd1;
  logic [FW-1:0] cfg_adr = '0, cfg_ce = '0, cfg_oe = '0, cfg_we = '0;
  logic [FW-1:0] cfg_rd_hld = '0, cfg_wr_hld = '0, cfg_pause = '0, cfg_post_rdy = '0;
  logic cfg_wait_en = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, rsp_rdata, bus_dout, bus_din = '0;
  logic [AW-1:0] bus_addr;
  logic bus_ce_n, bus_oe_n, bus_we_n, bus_dout_en;
  logic bus_wait_n = 1'b1;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_region_seq #(.DATA_W(DW), .ADDR_W(AW), .FIELD_W(FW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mult(cfg_mult),
    .cfg_adr(cfg_adr), .cfg_ce(cfg_ce), .cfg_oe(cfg_oe), .cfg_we(cfg_we),
    .cfg_rd_hld(cfg_rd_hld), .cfg_wr_hld(cfg_wr_hld), .cfg_pause(cfg_pause),
    .cfg_wait_en(cfg_wait_en), .cfg_post_rdy(cfg_post_rdy),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n),
    .bus_we_n(bus_we_n), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
    .bus_din(bus_din), .bus_wait_n(bus_wait_n)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] m, input int a, input int c, input int oe,
                         input int we, input int rh, input int wh, input int z,
                         input bit wen, input int post);
    cfg_mult = m; cfg_adr = FW'(a); cfg_ce = FW'(c); cfg_oe = FW'(oe); cfg_we = FW'(we);
    cfg_rd_hld = FW'(rh); cfg_wr_hld = FW'(wh); cfg_pause = FW'(z);
    cfg_wait_en = wen; cfg_post_rdy = FW'(post);
  endtask

  // One access, measured phase by phase at the pins.
  // wait_k > 0: wait low until the strobe has lasted wait_k clocks; wait_k < 0: held low.
  task automatic access(input string tag, input bit wr, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, input int ea, input int ec, input int es,
                        input int eh, input int ez, input int wait_k);
    int ca = 0, cc = 0, cs = 0, ch = 0, cz = 0, n = 0;
    bit seen_ce = 0, seen_stb = 0, got = 0, bad_addr = 0, bad_wd = 0, bad_stb = 0;
    logic [DW-1:0] rd = '0;
    @(negedge clk);
    bus_wait_n = (wait_k != 0) ? 1'b0 : 1'b1;
    req_write = wr; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    while (!got && n < 3000) begin
      @(negedge clk);
      n++;
      if (req_ready) begin
        got = 1;
        rd = rsp_rdata;
        req_valid = 1'b0;
      end else if (bus_ce_n) begin
        if (!seen_ce) ca++; else cz++;
        if (!bus_oe_n || !bus_we_n) bad_stb = 1;
      end else begin
        seen_ce = 1;
        if (bus_addr != a) bad_addr = 1;
        if (wr && (!bus_dout_en || bus_dout != wd)) bad_wd = 1;
        if (wr ? !bus_oe_n : !bus_we_n) bad_stb = 1;
        if (wr ? !bus_we_n : !bus_oe_n) begin
          seen_stb = 1;
          cs++;
          if (!wr) bus_din = RD_BASE + DW'(cs);
          if (wait_k > 0 && cs == wait_k) bus_wait_n = 1'b1;
        end else if (!seen_stb) cc++;
        else ch++;
      end
    end
    chk(got, {tag, " R12 ready seen"}, got, 1);
    chk(ca == ea, {tag, " R2 address setup clocks"}, ca, ea);
    chk(cc == ec, {tag, " R3 ce-to-strobe clocks"}, cc, ec);
    chk(cs == es, {tag, " R4 strobe clocks"}, cs, es);
    chk(ch == eh, {tag, " R5 hold clocks"}, ch, eh);
    chk(cz == ez, {tag, " R6 pause clocks"}, cz, ez);
    chk(!bad_addr, {tag, " R2 address during ce"}, bad_addr, 0);
    chk(!bad_stb, {tag, " R4 wrong strobe"}, bad_stb, 0);
    if (wr) chk(!bad_wd, {tag, " R10 write data driven"}, bad_wd, 0);
    else    chk(rd == RD_BASE + DW'(es), {tag, " R9 read data"}, int'(rd), int'(RD_BASE + DW'(es)));
    @(negedge clk);
    chk(!req_ready && bus_ce_n, {tag, " R12 single ready pulse"}, req_ready, 0);
    bus_wait_n = 1'b1;
  endtask

  task automatic t_reset;
    chk(bus_ce_n && bus_oe_n && bus_we_n, "R1 strobes idle in reset",
        {bus_ce_n, bus_oe_n, bus_we_n}, 7);
    chk(!req_ready && !bus_dout_en, "R1 ready and drive low in reset", {req_ready, bus_dout_en}, 0);
  endtask

  task automatic t_read_x1;
    set_cfg(2'd1, 2, 1, 3, 6, 2, 4, 1, 1'b0, 0);
    access("read x1", 1'b0, 16'h1234, '0, 2, 1, 3, 2, 1, 0);
  endtask

  task automatic t_write_x1;
    set_cfg(2'd1, 2, 1, 3, 5, 2, 1, 3, 1'b0, 0);
    access("write x1", 1'b1, 16'h0ABC, 16'h5AC3, 2, 1, 5, 1, 3, 0);
  endtask

  task automatic t_mult;
    set_cfg(2'd0, 1, 1, 2, 2, 1, 1, 1, 1'b0, 0);
    access("R7 code0 x4", 1'b0, 16'h0010, '0, 4, 4, 8, 4, 4, 0);
    set_cfg(2'd2, 1, 2, 1, 3, 2, 1, 1, 1'b0, 0);
    access("R7 code2 x2", 1'b1, 16'h0020, 16'h1111, 2, 4, 6, 2, 2, 0);
    set_cfg(2'd3, 1, 0, 1, 1, 1, 1, 0, 1'b0, 0);
    access("R7 code3 x8", 1'b0, 16'h0030, '0, 8, 0, 8, 8, 0, 0);
  endtask

  task automatic t_zero;
    set_cfg(2'd1, 0, 0, 1, 1, 0, 0, 0, 1'b0, 0);
    access("zero phases", 1'b0, 16'h0040, '0, 0, 0, 1, 0, 0, 0);
    access("zero phases wr", 1'b1, 16'h0041, 16'hBEEF, 0, 0, 1, 0, 0, 0);
  endtask

  task automatic t_wait;
    set_cfg(2'd1, 1, 1, 2, 2, 1, 1, 1, 1'b0, 3);
    access("R8 wait disabled", 1'b0, 16'h0050, '0, 1, 1, 2, 1, 1, -1);
    set_cfg(2'd1, 1, 1, 2, 2, 1, 1, 1, 1'b1, 3);
    access("R8 wait stretch", 1'b0, 16'h0051, '0, 1, 1, 9, 1, 1, 6);
    access("R8 wait ready early", 1'b1, 16'h0052, 16'h7777, 1, 1, 5, 1, 1, 0);
  endtask

  task automatic t_disabled;
    int viol = 0;
    set_cfg(2'd1, 1, 1, 1, 1, 1, 1, 1, 1'b0, 0);
    @(negedge clk);
    cfg_en = 1'b0;
    req_write = 1'b0; req_addr = 16'h0060; req_valid = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!bus_ce_n || req_ready) viol++;
    end
    chk(viol == 0, "R11 disabled region ignores request", viol, 0);
    req_valid = 1'b0;
    @(negedge clk);
    cfg_en = 1'b1;
    access("R11 re-enabled", 1'b0, 16'h0061, '0, 1, 1, 1, 1, 1, 0);
  endtask

  task automatic t_back2back;
    set_cfg(2'd1, 1, 2, 2, 3, 1, 2, 2, 1'b0, 0);
    access("R12 b2b first", 1'b1, 16'h0070, 16'h0F0F, 1, 2, 3, 2, 2, 0);
    access("R12 b2b second", 1'b0, 16'h0071, '0, 1, 2, 2, 1, 2, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_read_x1;
    t_write_x1;
    t_mult;
    t_zero;
    t_wait;
    t_disabled;
    t_back2back;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule